// File: doc/BRIEF.md
# Toggle-Handshake Word Synchronizer

This block moves one multi-bit word at a time from a source clock domain into a destination clock domain that has no fixed phase or frequency relationship to it. The source offers a word on its data bus while its ready input is high. The block takes the word only when it is idle. It holds the word in a launch register and flips a single forward toggle flop on the same source edge.

The forward toggle is passed through a chain of synchronizer flops in the destination domain. A change on the synchronized value makes the destination copy the launch register into its output register. At the same time it raises a load strobe for exactly one destination cycle and flips a feedback toggle flop. The feedback toggle is synchronized back into the source domain. When its change is seen there, the source becomes idle again and raises its next-word output.

The data bus itself is never synchronized. It is read in the destination only after the control bit has settled through the synchronizer. The bus therefore behaves as a multi-cycle path with at least two destination edges between launch and capture. Only one flop-driven control bit crosses in each direction.

Top module: `hs_mcp_xfer`

## Requirements
- R1: After reset of both domains, `src_next` is 1, `dst_load` is 0 and `dst_data` is all zeros.
- R2: A word is accepted on a rising `src_clk` edge where `src_rdy` and `src_next` are both 1. `src_next` is 0 in the cycle after that edge, and `src_next` never falls without such an acceptance.
- R3: While `src_next` is 0, changes on `src_rdy` and `src_data` have no effect. No extra word reaches the destination, and the word in flight is delivered unchanged.
- R4: Each accepted word produces exactly one `dst_load` pulse, one `dst_clk` cycle wide. During that pulse `dst_data` equals the accepted word.
- R5: `dst_data` changes only in a cycle where `dst_load` is 1. Between pulses, and after the last word, it holds the last delivered word.
- R6: Words reach the destination in acceptance order, with no word dropped or duplicated. This holds both with a faster and with a slower destination clock than the source clock.
- R7: `src_next` returns to 1 only after the outstanding word has been loaded at the destination.
- R8: `src_rdy` may be held high across several words. A new word is taken only on the first edge at which the block is idle again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| src_clk | input | 1 | Source domain clock |
| src_rst | input | 1 | Source domain synchronous reset, active high |
| src_rdy | input | 1 | Source has a word to send (level) |
| src_data | input | DATA_W | Word offered by the source |
| src_next | output | 1 | Block is idle and will take a word |
| dst_clk | input | 1 | Destination domain clock |
| dst_rst | input | 1 | Destination domain synchronous reset, active high |
| dst_load | output | 1 | One-cycle strobe marking a newly delivered word |
| dst_data | output | DATA_W | Last delivered word, held between strobes |

## Verification
The hardest case to create is a change on the source data bus while a transfer is still in flight. The stimulus holds `src_rdy` high across words and puts a junk value on `src_data` straight after each acceptance. The received sequence then exposes any launch-register update or any double acceptance. The same word table is run twice, once with the destination clock faster than the source clock and once with it slower. This makes the round trip of the toggles settle under both orderings. At each rise of `src_next` the bench checks that the destination has already counted the word.

// File: rtl/hs_xfer_pkg.sv
package hs_xfer_pkg;

    localparam int HS_DEF_WIDTH  = 16;
    localparam int HS_DEF_STAGES = 2;
    localparam int HS_MIN_STAGES = 2;

    typedef enum logic {
        XF_IDLE = 1'b0,
        XF_BUSY = 1'b1
    } xf_state_e;

    typedef struct packed {
        xf_state_e state;
        logic      fwd_tgl;
    } src_ctl_t;

    typedef struct packed {
        logic load;
        logic fb_tgl;
    } dst_ctl_t;

    function automatic int hs_clamp_stages(input int req);
        return (req < HS_MIN_STAGES) ? HS_MIN_STAGES : req;
    endfunction

    function automatic logic hs_changed(input logic now_v, input logic old_v);
        return now_v ^ old_v;
    endfunction

endpackage

// File: rtl/hs_sync_edge.sv
module hs_sync_edge
    import hs_xfer_pkg::*;
#(
    parameter int SYNC_STAGES = HS_DEF_STAGES
) (
    input  logic clk,
    input  logic rst,
    input  logic d_async,
    output logic flip
);

    localparam int N = hs_clamp_stages(SYNC_STAGES);

    logic [N-1:0] chain_q;
    logic         seen_q;

    // first flop feeds only the next stage of the chain
    always_ff @(posedge clk) begin
        if (rst) chain_q[0] <= 1'b0;
        else     chain_q[0] <= d_async;
    end

    genvar g;
    generate
        for (g = 1; g < N; g++) begin : g_stage
            always_ff @(posedge clk) begin
                if (rst) chain_q[g] <= 1'b0;
                else     chain_q[g] <= chain_q[g-1];
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) seen_q <= 1'b0;
        else     seen_q <= chain_q[N-1];
    end

    assign flip = hs_changed(chain_q[N-1], seen_q);

endmodule

// File: rtl/hs_src_launch.sv
module hs_src_launch
    import hs_xfer_pkg::*;
#(
    parameter int DATA_W      = HS_DEF_WIDTH,
    parameter int SYNC_STAGES = HS_DEF_STAGES
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rdy,
    input  logic [DATA_W-1:0] din,
    input  logic              fb_async,
    output logic              next,
    output logic [DATA_W-1:0] launch_word,
    output logic              fwd_tgl
);

    src_ctl_t          ctl_q, ctl_d;
    logic [DATA_W-1:0] word_q, word_d;
    logic              fb_flip;
    logic              take;

    hs_sync_edge #(.SYNC_STAGES(SYNC_STAGES)) u_fb_sync (
        .clk     (clk),
        .rst     (rst),
        .d_async (fb_async),
        .flip    (fb_flip)
    );

    assign take = rdy && (ctl_q.state == XF_IDLE);

    always_comb begin
        ctl_d  = ctl_q;
        word_d = word_q;
        if (take) begin
            word_d        = din;
            ctl_d.fwd_tgl = ~ctl_q.fwd_tgl;
            ctl_d.state   = XF_BUSY;
        end else if (fb_flip && ctl_q.state == XF_BUSY) begin
            ctl_d.state   = XF_IDLE;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q  <= '{state: XF_IDLE, fwd_tgl: 1'b0};
            word_q <= '0;
        end else begin
            ctl_q  <= ctl_d;
            word_q <= word_d;
        end
    end

    assign next        = (ctl_q.state == XF_IDLE);
    assign launch_word = word_q;
    assign fwd_tgl     = ctl_q.fwd_tgl;

endmodule

// File: rtl/hs_dst_capture.sv
module hs_dst_capture
    import hs_xfer_pkg::*;
#(
    parameter int DATA_W      = HS_DEF_WIDTH,
    parameter int SYNC_STAGES = HS_DEF_STAGES
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              fwd_async,
    input  logic [DATA_W-1:0] word_mcp,
    output logic              load,
    output logic [DATA_W-1:0] dout,
    output logic              fb_tgl
);

    dst_ctl_t          ctl_q, ctl_d;
    logic [DATA_W-1:0] hold_q, hold_d;
    logic              fwd_flip;

    hs_sync_edge #(.SYNC_STAGES(SYNC_STAGES)) u_fwd_sync (
        .clk     (clk),
        .rst     (rst),
        .d_async (fwd_async),
        .flip    (fwd_flip)
    );

    always_comb begin
        ctl_d      = ctl_q;
        hold_d     = hold_q;
        ctl_d.load = 1'b0;
        if (fwd_flip) begin
            // word_mcp has been stable for at least SYNC_STAGES edges here
            hold_d       = word_mcp;
            ctl_d.load   = 1'b1;
            ctl_d.fb_tgl = ~ctl_q.fb_tgl;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q  <= '{load: 1'b0, fb_tgl: 1'b0};
            hold_q <= '0;
        end else begin
            ctl_q  <= ctl_d;
            hold_q <= hold_d;
        end
    end

    assign load   = ctl_q.load;
    assign dout   = hold_q;
    assign fb_tgl = ctl_q.fb_tgl;

endmodule

// File: rtl/hs_mcp_xfer.sv
module hs_mcp_xfer
    import hs_xfer_pkg::*;
#(
    parameter int DATA_W      = HS_DEF_WIDTH,
    parameter int SYNC_STAGES = HS_DEF_STAGES
) (
    input  logic              src_clk,
    input  logic              src_rst,
    input  logic              src_rdy,
    input  logic [DATA_W-1:0] src_data,
    output logic              src_next,
    input  logic              dst_clk,
    input  logic              dst_rst,
    output logic              dst_load,
    output logic [DATA_W-1:0] dst_data
);

    logic [DATA_W-1:0] launch_word;
    logic              fwd_tgl;
    logic              fb_tgl;

    hs_src_launch #(
        .DATA_W      (DATA_W),
        .SYNC_STAGES (SYNC_STAGES)
    ) u_src (
        .clk         (src_clk),
        .rst         (src_rst),
        .rdy         (src_rdy),
        .din         (src_data),
        .fb_async    (fb_tgl),
        .next        (src_next),
        .launch_word (launch_word),
        .fwd_tgl     (fwd_tgl)
    );

    hs_dst_capture #(
        .DATA_W      (DATA_W),
        .SYNC_STAGES (SYNC_STAGES)
    ) u_dst (
        .clk       (dst_clk),
        .rst       (dst_rst),
        .fwd_async (fwd_tgl),
        .word_mcp  (launch_word),
        .load      (dst_load),
        .dout      (dst_data),
        .fb_tgl    (fb_tgl)
    );

endmodule

// File: rtl/hs_mcp_xfer_chk.sv
module hs_mcp_xfer_chk #(
    parameter int DATA_W = 16
) (
    input logic              src_clk,
    input logic              src_rst,
    input logic              src_rdy,
    input logic              src_next,
    input logic [DATA_W-1:0] launch_word,
    input logic              fwd_tgl,
    input logic              dst_clk,
    input logic              dst_rst,
    input logic              dst_load,
    input logic [DATA_W-1:0] dst_data
);

    // R2
    accept_drops_next_chk: assert property (@(posedge src_clk) disable iff (src_rst)
        (src_rdy && src_next) |=> !src_next);

    // R2
    next_falls_on_accept_chk: assert property (@(posedge src_clk) disable iff (src_rst)
        $fell(src_next) |-> $past(src_rdy));

    // R3
    launch_held_chk: assert property (@(posedge src_clk) disable iff (src_rst)
        !src_next |=> ($stable(launch_word) && $stable(fwd_tgl)));

    // R4
    load_one_cycle_chk: assert property (@(posedge dst_clk) disable iff (dst_rst)
        dst_load |=> !dst_load);

    // R4
    load_matches_launch_chk: assert property (@(posedge dst_clk) disable iff (dst_rst)
        dst_load |-> (dst_data == launch_word));

    // R5
    data_held_chk: assert property (@(posedge dst_clk) disable iff (dst_rst)
        !dst_load |-> $stable(dst_data));

endmodule

bind hs_mcp_xfer hs_mcp_xfer_chk #(.DATA_W(DATA_W)) u_chk (
    .src_clk     (src_clk),
    .src_rst     (src_rst),
    .src_rdy     (src_rdy),
    .src_next    (src_next),
    .launch_word (launch_word),
    .fwd_tgl     (fwd_tgl),
    .dst_clk     (dst_clk),
    .dst_rst     (dst_rst),
    .dst_load    (dst_load),
    .dst_data    (dst_data)
);

// File: tb/sim_hs_mcp_xfer.sv
module sim_hs_mcp_xfer;

    localparam int W = 16;
    localparam int NV = 12;
    // {hold rdy high after acceptance, word}
    localparam logic [W:0] VEC [NV] = '{
        {1'b0, 16'hA5C3}, {1'b1, 16'h0001}, {1'b1, 16'hFFFF}, {1'b0, 16'h0000},
        {1'b1, 16'h8000}, {1'b1, 16'h1234}, {1'b0, 16'h1234}, {1'b1, 16'h5A5A},
        {1'b0, 16'hDEAD}, {1'b1, 16'hBEEF}, {1'b1, 16'h7FFE}, {1'b0, 16'hC001}
    };

    logic         src_clk = 1'b0, dst_clk = 1'b0;
    logic         src_rst = 1'b1, dst_rst = 1'b1;
    logic         src_rdy = 1'b0;
    logic [W-1:0] src_data = '0;
    logic         src_next, dst_load;
    logic [W-1:0] dst_data;

    int checks = 0, errors = 0;
    int dst_half = 7;
    int tx_cnt = 0, rx_cnt = 0;
    logic [W-1:0] tx_mem [64];
    logic [W-1:0] rx_mem [64];
    logic prev_load = 1'b0;
    bit done = 0;

    hs_mcp_xfer #(.DATA_W(W), .SYNC_STAGES(2)) u0 (
        .src_clk(src_clk), .src_rst(src_rst), .src_rdy(src_rdy), .src_data(src_data),
        .src_next(src_next), .dst_clk(dst_clk), .dst_rst(dst_rst),
        .dst_load(dst_load), .dst_data(dst_data)
    );

    always #10 src_clk = ~src_clk;
    initial forever #(dst_half) dst_clk = ~dst_clk;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    always @(negedge dst_clk) begin
        if (dst_rst) begin
            prev_load = 1'b0;
        end else begin
            if (dst_load) begin
                if (prev_load) chk(1'b0, "R4 load wider than one cycle", 1, 0);
                if (rx_cnt < 64) rx_mem[rx_cnt] = dst_data;
                rx_cnt++;
            end
            prev_load = dst_load;
        end
    end

    task automatic send(input logic [W:0] v);
        while (!src_next) @(negedge src_clk);
        // R7: word before this one must already be loaded
        chk(rx_cnt == tx_cnt, "R7 next before load", rx_cnt, tx_cnt);
        src_rdy  = 1'b1;
        src_data = v[W-1:0];
        @(negedge src_clk);
        chk(src_next == 1'b0, "R2 next after accept", int'(src_next), 0);
        tx_mem[tx_cnt] = v[W-1:0];
        tx_cnt++;
        if (v[W]) begin
            // R8 / R3: rdy stays high with junk data while busy
            src_data = ~v[W-1:0] ^ 16'h3C3C;
        end else begin
            src_rdy = 1'b0;
        end
    endtask

    initial begin
        for (int ph = 0; ph < 2; ph++) begin
            dst_half = (ph == 0) ? 7 : 23;
            src_rst = 1'b1; dst_rst = 1'b1; src_rdy = 1'b0;
            repeat (6) @(negedge src_clk);
            #150;
            @(negedge src_clk);
            src_rst = 1'b0; dst_rst = 1'b0;
            tx_cnt = 0; rx_cnt = 0;
            @(negedge src_clk);
            chk(src_next == 1'b1, "R1 src_next", int'(src_next), 1);
            chk(dst_load == 1'b0, "R1 dst_load", int'(dst_load), 0);
            chk(dst_data == '0, "R1 dst_data", int'(dst_data), 0);
            // R8: rdy held high across consecutive words in the table
            for (int i = 0; i < NV; i++) send(VEC[i]);
            src_rdy = 1'b0;
            while (!src_next) @(negedge src_clk);
            chk(rx_cnt == tx_cnt, "R7 final next", rx_cnt, tx_cnt);
            repeat (40) @(negedge src_clk);
            // R3 / R6: exact count, no extra word from junk data
            chk(rx_cnt == NV, "R6 word count", rx_cnt, NV);
            for (int i = 0; i < NV; i++)
                chk(rx_mem[i] == VEC[i][W-1:0], "R6 word order/value",
                    int'(rx_mem[i]), int'(VEC[i][W-1:0]));
            // R5: output holds last word when idle
            chk(dst_data == VEC[NV-1][W-1:0], "R5 held data",
                int'(dst_data), int'(VEC[NV-1][W-1:0]));
            chk(dst_load == 1'b0, "R5 no load while idle", int'(dst_load), 0);
        end
        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #3000000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog R6 actual=%0d expected=%0d", rx_cnt, tx_cnt);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule